// File: doc/BRIEF.md
# Wavefront SIMD Cadence Unit

This block steps one 64-lane wavefront instruction across a 16-lane vector datapath, one quarter of the lanes per clock. The operation class picks how many times the four quarters are swept. Single precision takes one sweep, a double-precision add takes two, and a double-precision multiply or transcendental takes four. While the instruction runs, the unit drives a 16-bit lane-enable strobe for the active quarter and raises a busy flag. A small integer stand-in result is written into a per-lane register. Real floating-point arithmetic is not modelled.

A 64-bit execution mask gates every lane write. The scalar side steers the mask with three commands that together implement divergent if/else code. The first saves the mask and narrows it by a compare result. The second flips the mask against the saved copy. The third restores the saved copy. Two zero flags, one on the mask and one on the incoming compare vector, let the scalar side skip a code section when no lane would execute it. A read port exposes any lane's result register.

Top module: `simd_cadence_unit`

## Requirements
- R1: After reset, busy is 0, quarter_en is 0, the execution mask is all ones, the saved mask is all ones and every lane result register reads 0.
- R2: An issue with issue_op = 0 (single precision) accepted at a clock edge holds busy high for exactly 4 cycles after that edge.
- R3: issue_op = 1 (double-precision add) holds busy high for exactly 8 cycles.
- R4: issue_op = 2 (double-precision multiply) and issue_op = 3 (transcendental) hold busy high for exactly 16 cycles.
- R5: While busy is high, quarter_idx steps 0,1,2,3 and repeats, starting at 0. quarter_en equals exec_mask bits [16*q+15:16*q] for the current quarter q. quarter_en is 0 whenever busy is low.
- R6: issue_valid is accepted only while busy is low. An issue presented while busy is high starts nothing and writes nothing.
- R7: mask_cmd = 1 (if) copies exec_mask into the saved mask and sets exec_mask to exec_mask AND cmp_result. The new value is visible in the cycle after the edge.
- R8: mask_cmd = 2 (else) sets exec_mask to saved mask AND NOT exec_mask.
- R9: mask_cmd = 3 (restore) sets exec_mask to the saved mask. mask_cmd = 0 leaves it unchanged.
- R10: During its quarter, a lane whose mask bit is 1 has its register written with (operand + lane index) mod 2^8. A lane whose mask bit is 0 keeps its old value.
- R11: exec_zero is 1 exactly when exec_mask is all zero. cmp_zero is 1 exactly when cmp_result is all zero.
- R12: mask_cmd is ignored while busy is high, and exec_mask stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction issue request |
| issue_op | input | 2 | Operation class: 0 SP, 1 DP add, 2 DP mul, 3 transcendental |
| issue_operand | input | 8 | Stand-in operand captured at issue |
| cmp_result | input | 64 | Per-lane vector compare result |
| mask_cmd | input | 2 | 0 hold, 1 if, 2 else, 3 restore |
| busy | output | 1 | Instruction in progress |
| quarter_idx | output | 2 | Quarter currently executing |
| quarter_en | output | 16 | Lane-enable strobe of the active quarter |
| exec_mask | output | 64 | Current execution mask |
| exec_zero | output | 1 | Execution mask is all zero |
| cmp_zero | output | 1 | Compare result is all zero |
| lane_sel | input | 6 | Lane selected for read-back |
| lane_data | output | 8 | Result register of the selected lane |

## Verification
An issue accepted at edge E makes busy and quarter 0 visible right after E. The strobe for quarter k of sweep p is due in the (4p+k+1)-th cycle after E. Busy falls after the last of 4, 8 or 16 such cycles. The driver queues one expected index/strobe pair per due cycle, and the monitor pops one pair at each falling edge while busy is high, so a missing, extra or misordered cycle fails. Mask commands take effect at the next edge and are checked one time unit after it. The zero flags and the lane read port are combinational and are checked a time unit after their inputs settle.

// File: rtl/simd_cadence_pkg.sv
package simd_cadence_pkg;
   typedef enum logic [1:0] {
      OPC_SP    = 2'd0,
      OPC_DADD  = 2'd1,
      OPC_DMUL  = 2'd2,
      OPC_TRANS = 2'd3
   } opc_e;

   typedef enum logic [1:0] {
      MSK_HOLD    = 2'd0,
      MSK_IF      = 2'd1,
      MSK_ELSE    = 2'd2,
      MSK_RESTORE = 2'd3
   } mskcmd_e;
endpackage

// File: rtl/cadence_seq.sv
module cadence_seq #(
   parameter int QUARTERS = 4,
   parameter int QW       = 2,
   parameter int PW       = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [PW-1:0] passes_m1,
   output logic          busy,
   output logic [QW-1:0] qidx
);
   localparam logic [QW-1:0] QLAST = QW'(QUARTERS - 1);

   initial begin
      if (QUARTERS < 2) $error("cadence_seq: QUARTERS must be at least 2");
   end

   logic [PW-1:0] pass_q, plim_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         qidx   <= '0;
         pass_q <= '0;
         plim_q <= '0;
      end else if (!busy) begin
         if (start) begin
            busy   <= 1'b1;
            qidx   <= '0;
            pass_q <= '0;
            plim_q <= passes_m1;
         end
      end else if (qidx == QLAST) begin
         qidx <= '0;
         if (pass_q == plim_q) busy   <= 1'b0;
         else                  pass_q <= pass_q + 1'b1;
      end else begin
         qidx <= qidx + 1'b1;
      end
   end
endmodule

// File: rtl/exec_mask_unit.sv
module exec_mask_unit #(
   parameter int LANES = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_en,
   input  logic [1:0]       cmd,
   input  logic [LANES-1:0] cmp,
   output logic [LANES-1:0] mask
);
   import simd_cadence_pkg::*;

   logic [LANES-1:0] saved_q;
   mskcmd_e          op;
   assign op = mskcmd_e'(cmd);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask    <= '1;
         saved_q <= '1;
      end else if (cmd_en) begin
         case (op)
            MSK_IF: begin
               saved_q <= mask;
               mask    <= mask & cmp;
            end
            MSK_ELSE:    mask <= saved_q & ~mask;
            MSK_RESTORE: mask <= saved_q;
            default:     mask <= mask;
         endcase
      end
   end
endmodule

// File: rtl/lane_bank.sv
module lane_bank #(
   parameter int LANES  = 64,
   parameter int SIMD_W = 16,
   parameter int DATA_W = 8,
   parameter int QW     = 2,
   parameter int LW     = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [QW-1:0]     qidx,
   input  logic [SIMD_W-1:0] wr_en,
   input  logic [DATA_W-1:0] operand,
   input  logic [LW-1:0]     rd_sel,
   output logic [DATA_W-1:0] rd_data
);
   localparam int QUARTERS = LANES / SIMD_W;

   logic [DATA_W-1:0] regs [LANES];

   for (genvar g = 0; g < QUARTERS; g++) begin : g_quarter
      for (genvar l = 0; l < SIMD_W; l++) begin : g_lane
         localparam int IDX = g * SIMD_W + l;
         always_ff @(posedge clk) begin
            if (!rst_n)
               regs[IDX] <= '0;
            else if (qidx == QW'(g) && wr_en[l])
               regs[IDX] <= operand + DATA_W'(IDX);
         end
      end
   end

   assign rd_data = regs[rd_sel];
endmodule

// File: rtl/simd_cadence_unit.sv
module simd_cadence_unit #(
   parameter int LANES        = 64,
   parameter int SIMD_W       = 16,
   parameter int DATA_W       = 8,
   parameter int DADD_PASSES  = 2,
   parameter int LONG_PASSES  = 4,
   localparam int QUARTERS    = LANES / SIMD_W,
   localparam int QW          = $clog2(QUARTERS),
   localparam int LW          = $clog2(LANES),
   localparam int PW          = $clog2(LONG_PASSES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_valid,
   input  logic [1:0]        issue_op,
   input  logic [DATA_W-1:0] issue_operand,
   input  logic [LANES-1:0]  cmp_result,
   input  logic [1:0]        mask_cmd,
   output logic              busy,
   output logic [QW-1:0]     quarter_idx,
   output logic [SIMD_W-1:0] quarter_en,
   output logic [LANES-1:0]  exec_mask,
   output logic              exec_zero,
   output logic              cmp_zero,
   input  logic [LW-1:0]     lane_sel,
   output logic [DATA_W-1:0] lane_data
);
   import simd_cadence_pkg::*;

   initial begin
      if (LANES % SIMD_W != 0) $error("simd_cadence_unit: LANES not a multiple of SIMD_W");
      if ((1 << QW) != QUARTERS) $error("simd_cadence_unit: quarter count must be a power of two");
      if (DADD_PASSES < 1 || LONG_PASSES < DADD_PASSES) $error("simd_cadence_unit: bad pass counts");
   end

   logic          accept;
   logic [PW-1:0] passes_m1;
   logic [DATA_W-1:0] operand_q;

   assign accept = issue_valid && !busy;

   always_comb begin
      case (opc_e'(issue_op))
         OPC_SP:   passes_m1 = '0;
         OPC_DADD: passes_m1 = PW'(DADD_PASSES - 1);
         default:  passes_m1 = PW'(LONG_PASSES - 1);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      operand_q <= '0;
      else if (accept) operand_q <= issue_operand;
   end

   cadence_seq #(.QUARTERS(QUARTERS), .QW(QW), .PW(PW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (issue_valid),
      .passes_m1 (passes_m1),
      .busy      (busy),
      .qidx      (quarter_idx)
   );

   exec_mask_unit #(.LANES(LANES)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmd_en (!busy),
      .cmd    (mask_cmd),
      .cmp    (cmp_result),
      .mask   (exec_mask)
   );

   assign quarter_en = busy ? exec_mask[quarter_idx*SIMD_W +: SIMD_W] : '0;
   assign exec_zero  = ~|exec_mask;
   assign cmp_zero   = ~|cmp_result;

   lane_bank #(.LANES(LANES), .SIMD_W(SIMD_W), .DATA_W(DATA_W), .QW(QW), .LW(LW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .qidx    (quarter_idx),
      .wr_en   (quarter_en),
      .operand (operand_q),
      .rd_sel  (lane_sel),
      .rd_data (lane_data)
   );
endmodule

// File: rtl/simd_cadence_chk.sv
module simd_cadence_chk #(
   parameter int LANES  = 64,
   parameter int SIMD_W = 16,
   localparam int QUARTERS = LANES / SIMD_W,
   localparam int QW       = $clog2(QUARTERS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              issue_valid,
   input logic [1:0]        mask_cmd,
   input logic [LANES-1:0]  cmp_result,
   input logic              busy,
   input logic [QW-1:0]     quarter_idx,
   input logic [SIMD_W-1:0] quarter_en,
   input logic [LANES-1:0]  exec_mask
);
   localparam logic [QW-1:0] QLAST = QW'(QUARTERS - 1);

   assert_start_needs_issue_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(issue_valid));

   assert_first_quarter_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> quarter_idx == '0);

   assert_quarter_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && quarter_idx != QLAST) |=> (busy && quarter_idx == QW'($past(quarter_idx) + 1'b1)));

   assert_idle_no_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> quarter_en == '0);

   assert_mask_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(exec_mask));

   assert_if_narrows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && mask_cmd == 2'd1) |=> exec_mask == ($past(exec_mask) & $past(cmp_result)));
endmodule

bind simd_cadence_unit simd_cadence_chk #(.LANES(LANES), .SIMD_W(SIMD_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .issue_valid (issue_valid),
   .mask_cmd    (mask_cmd),
   .cmp_result  (cmp_result),
   .busy        (busy),
   .quarter_idx (quarter_idx),
   .quarter_en  (quarter_en),
   .exec_mask   (exec_mask)
);

// File: tb/tb_simd_cadence_unit.sv
module tb_simd_cadence_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_valid = 1'b0;
   logic [1:0]  issue_op = 2'd0;
   logic [7:0]  issue_operand = 8'd0;
   logic [63:0] cmp_result = 64'd0;
   logic [1:0]  mask_cmd = 2'd0;
   logic        busy;
   logic [1:0]  quarter_idx;
   logic [15:0] quarter_en;
   logic [63:0] exec_mask;
   logic        exec_zero, cmp_zero;
   logic [5:0]  lane_sel = 6'd0;
   logic [7:0]  lane_data;

   simd_cadence_unit dut (
      .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
      .issue_operand(issue_operand), .cmp_result(cmp_result), .mask_cmd(mask_cmd),
      .busy(busy), .quarter_idx(quarter_idx), .quarter_en(quarter_en),
      .exec_mask(exec_mask), .exec_zero(exec_zero), .cmp_zero(cmp_zero),
      .lane_sel(lane_sel), .lane_data(lane_data)
   );

   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   logic [17:0] expq [$];
   logic [63:0] m_mask = '1, m_saved = '1;
   logic [7:0]  m_regs [64];

   task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: one expected {quarter, strobe} per busy cycle
   always @(negedge clk) begin
      if (rst_n && busy) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R2/R3/R4 busy longer than expected", 64'(busy), 64'd0);
         end else begin
            logic [17:0] e;
            e = expq.pop_front();
            chk({quarter_idx, quarter_en} == e, "R5 quarter/strobe", 64'({quarter_idx, quarter_en}), 64'(e));
         end
      end
   end

   task automatic issue(input logic [1:0] op, input logic [7:0] opnd);
      int passes;
      passes = (op == 2'd0) ? 1 : (op == 2'd1) ? 2 : 4;
      issue_valid = 1'b1; issue_op = op; issue_operand = opnd;
      for (int p = 0; p < passes; p++)
         for (int q = 0; q < 4; q++)
            expq.push_back({2'(q), m_mask[q*16 +: 16]});
      for (int l = 0; l < 64; l++)
         if (m_mask[l]) m_regs[l] = opnd + 8'(l);
      @(posedge clk); #1;
      issue_valid = 1'b0;
   endtask

   task automatic wait_idle(input string tag);
      while (busy) @(posedge clk);
      #1;
      chk(expq.size() == 0, tag, 64'(expq.size()), 64'd0);
   endtask

   task automatic mcmd(input logic [1:0] c, input logic [63:0] cmpv);
      mask_cmd = c; cmp_result = cmpv;
      @(posedge clk); #1;
      mask_cmd = 2'd0;
      case (c)
         2'd1: begin m_saved = m_mask; m_mask = m_mask & cmpv; end
         2'd2: m_mask = m_saved & ~m_mask;
         2'd3: m_mask = m_saved;
         default: ;
      endcase
   endtask

   task automatic check_lanes(input string tag);
      int bad;
      bad = 0;
      for (int l = 0; l < 64; l++) begin
         lane_sel = 6'(l); #1;
         if (lane_data !== m_regs[l]) begin
            bad++;
            chk(1'b0, tag, 64'(lane_data), 64'(m_regs[l]));
         end
      end
      if (bad == 0) chk(1'b1, tag, 0, 0);
   endtask

   initial begin
      #2_000_000;
      chk(1'b0, "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int l = 0; l < 64; l++) m_regs[l] = 8'd0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      // R1
      chk(busy == 1'b0, "R1 busy", 64'(busy), 0);
      chk(quarter_en == 16'd0, "R1 quarter_en", 64'(quarter_en), 0);
      chk(exec_mask == '1, "R1 mask", exec_mask, '1);
      check_lanes("R1 lanes zero");

      // R2, R10: single precision, full mask
      issue(2'd0, 8'h05);
      wait_idle("R2 SP length 4");
      check_lanes("R10 SP full mask writes");

      // R7 if
      mcmd(2'd1, 64'h00FF_0000_F0F0_1234);
      chk(exec_mask == m_mask, "R7 if narrows", exec_mask, m_mask);
      chk(exec_zero == 1'b0, "R11 exec_zero low", 64'(exec_zero), 0);
      // R3, R10
      issue(2'd1, 8'h09);
      wait_idle("R3 DP add length 8");
      check_lanes("R10 masked lanes kept");

      // R8 else
      mcmd(2'd2, 64'd0);
      chk(exec_mask == m_mask, "R8 else inverts", exec_mask, m_mask);

      // R4 multiply, with R6 ignored issue and R12 ignored mask command
      issue(2'd2, 8'h20);
      issue_valid = 1'b1; issue_op = 2'd3; issue_operand = 8'hEE;
      mask_cmd = 2'd3;
      @(posedge clk); #1;
      issue_valid = 1'b0; mask_cmd = 2'd0;
      chk(exec_mask == m_mask, "R12 mask held while busy", exec_mask, m_mask);
      wait_idle("R4/R6 DP mul length 16, second issue ignored");
      check_lanes("R6 ignored issue wrote nothing");

      // R9 restore, hold
      mcmd(2'd3, 64'd0);
      chk(exec_mask == m_mask, "R9 restore", exec_mask, m_mask);
      mcmd(2'd0, 64'hFFFF);
      chk(exec_mask == m_mask, "R9 hold unchanged", exec_mask, m_mask);

      // R4 transcendental
      issue(2'd3, 8'h33);
      wait_idle("R4 transcendental length 16");
      check_lanes("R10 trans writes");

      // R11 zero flags: all-failing compare
      cmp_result = 64'd0; #1;
      chk(cmp_zero == 1'b1, "R11 cmp_zero high", 64'(cmp_zero), 1);
      cmp_result = 64'h8000_0000_0000_0000; #1;
      chk(cmp_zero == 1'b0, "R11 cmp_zero low", 64'(cmp_zero), 0);
      mcmd(2'd1, 64'd0);
      chk(exec_zero == 1'b1, "R11 exec_zero high", 64'(exec_zero), 1);
      issue(2'd0, 8'h77);
      wait_idle("R5 empty mask strobes");
      check_lanes("R10 empty mask writes nothing");
      mcmd(2'd3, 64'd0);
      chk(exec_mask == '1, "R9 restore full", exec_mask, '1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule